// File: doc/BRIEF.md
# Saturating Semaphore Cell

A single inter-thread synchronization cell that keeps a 16-bit counting semaphore. Requesters reach it through a view code plus read and write strobes, with one strobe pair per cycle. A "take" is a read through one of the two semaphore views. It returns the count and lowers it by one. A "give" is a write through either semaphore view. It raises the count by one and stops at the all-ones value instead of wrapping.

A take in the waiting view that finds the count at zero does not complete. The requester's thread number is recorded in a waiter mask, and the block answers with a block response. The next give releases every recorded waiter at once by pulsing their bits on the wake vector, and then clears the mask. The thread number is 0 to NUM_THREADS-1 and is one-hot encoded into the mask and the wake vector. A raw view and a tag view are also provided so the cell can be inspected.

A cell built with the FIFO-type parameter set keeps its semaphore views inert.

Top module: `semaphoreCell`

## Requirements
- R1: After reset the count, the tag flags and the waiter mask are zero. `rdData`, `blockResp` and `wakeVec` are also zero.
- R2: Read results, block response and wake vector are registered, so they appear one clock after the strobe. A take (`rdEn`, view 4 = wait or view 5 = poll) with a count above zero returns the count as it was before the take (zero-extended) and then decrements it.
- R3: A take in view 4 with a count of zero returns 0 and asserts `blockResp` for one cycle. It records bit `threadId` in the waiter mask and leaves the count at zero.
- R4: A take in view 5 with a count of zero returns 0. It does not assert `blockResp` and records no waiter.
- R5: A give (`wrEn`, view 4 or 5) increments the count unless the count is 0xFFFF, where it stays. The write data is ignored, and views 4 and 5 give identically.
- R6: On a give, `wakeVec` shows the waiter mask as it was for one cycle, and the mask is cleared. A give with no waiters shows 0.
- R7: A read in view 0 (raw) returns the count. A write in view 0 changes nothing.
- R8: A read in view 1 (tag) returns a word with these fields: bit 17 = FIFO-type flag, bit 16 = T, bit 1 = F, bit 0 = E, and all other bits 0. A write in view 1 loads T, F and E from data bits 16, 1 and 0.
- R9: With FIFO_TAG=1, takes return 0 and never block, gives do nothing, and tag-view reads show bit 17 set.
- R10: A take and a give in the same cycle are applied as give first, then take. The read returns the count after the give.
- R11: Reads in views 2 and 3 return 0. Writes in views 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| viewSel | input | 4 | View code for this cycle's access |
| rdEn | input | 1 | Read (take / inspect) strobe |
| wrEn | input | 1 | Write (give / tag load) strobe |
| wrData | input | DATA_W | Write data, used by tag view only |
| threadId | input | TID_W | Requesting thread number |
| rdData | output | DATA_W | Registered read result |
| blockResp | output | 1 | One-cycle pulse: requester was parked |
| wakeVec | output | NUM_THREADS | One-cycle pulse of threads to release |

## Verification
The hardest situations to reach are the edges of the count range, together with takes and gives colliding in one cycle. Saturation is reached by a long run of back-to-back gives, followed by a single extra give and a take that shows the drop from 0xFFFF. Waiter handling is exercised by parking two distinct threads before a give, and then giving again to confirm the mask emptied. The collision case is driven both on an empty count and with a parked waiter present, so the give-first rule shows in the read value and in the wake vector of the same cycle.

// File: rtl/semCellPkg.sv
package semCellPkg;
  typedef enum logic [3:0] {
    VIEW_RAW      = 4'd0,
    VIEW_TAG      = 4'd1,
    VIEW_EF_WAIT  = 4'd2,
    VIEW_EF_POLL  = 4'd3,
    VIEW_SEM_WAIT = 4'd4,
    VIEW_SEM_POLL = 4'd5
  } viewT;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ZERO  = 2'd1,
    RD_COUNT = 2'd2,
    RD_TAG   = 2'd3
  } rdSelT;

  typedef struct packed {
    logic  give;
    logic  take;
    logic  park;
    logic  tagWr;
    rdSelT rdSel;
  } strobeT;

  localparam int TAG_E_BIT    = 0;
  localparam int TAG_F_BIT    = 1;
  localparam int TAG_T_BIT    = 16;
  localparam int TAG_FIFO_BIT = 17;
endpackage

// File: rtl/semCellCtrl.sv
module semCellCtrl
  import semCellPkg::*;
#(
  parameter bit FIFO_TAG = 1'b0
) (
  input  logic [3:0] viewSel,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       countZero,
  output strobeT     strb
);
  logic isSem;
  logic isWait;
  logic zeroAfterGive;

  always_comb begin
    isSem  = (viewSel == VIEW_SEM_WAIT) || (viewSel == VIEW_SEM_POLL);
    isWait = (viewSel == VIEW_SEM_WAIT);

    strb.give  = wrEn && isSem && !FIFO_TAG;
    // a give in the same cycle lands first, so zero can only persist without it
    zeroAfterGive = countZero && !strb.give;
    strb.take  = rdEn && isSem && !FIFO_TAG && !zeroAfterGive;
    strb.park  = rdEn && isWait && !FIFO_TAG && zeroAfterGive;
    strb.tagWr = wrEn && (viewSel == VIEW_TAG);

    if (!rdEn) begin
      strb.rdSel = RD_NONE;
    end else begin
      case (viewSel)
        VIEW_RAW:                     strb.rdSel = RD_COUNT;
        VIEW_TAG:                     strb.rdSel = RD_TAG;
        VIEW_SEM_WAIT, VIEW_SEM_POLL: strb.rdSel = FIFO_TAG ? RD_ZERO : RD_COUNT;
        default:                      strb.rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/semCellData.sv
module semCellData
  import semCellPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 64,
  parameter int NUM_THREADS = 8,
  parameter int TID_W       = 3,
  parameter bit FIFO_TAG    = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strb,
  input  logic [TID_W-1:0]       threadId,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic                   blockResp,
  output logic [NUM_THREADS-1:0] wakeVec,
  output logic                   countZero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]       count;
  logic [CNT_W-1:0]       countAfterGive;
  logic [NUM_THREADS-1:0] waitMask;
  logic [NUM_THREADS-1:0] parkBit;
  logic                   tagT, tagF, tagE;
  logic [DATA_W-1:0]      tagWord;

  always_comb begin
    countAfterGive = (strb.give && count != CNT_MAX) ? count + CNT_ONE : count;
    parkBit        = strb.park ? (NUM_THREADS'(1) << threadId) : '0;
    tagWord                = '0;
    tagWord[TAG_FIFO_BIT]  = FIFO_TAG;
    tagWord[TAG_T_BIT]     = tagT;
    tagWord[TAG_F_BIT]     = tagF;
    tagWord[TAG_E_BIT]     = tagE;
  end

  assign countZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      waitMask  <= '0;
      wakeVec   <= '0;
      blockResp <= 1'b0;
      rdData    <= '0;
      tagT      <= 1'b0;
      tagF      <= 1'b0;
      tagE      <= 1'b0;
    end else begin
      count     <= strb.take ? countAfterGive - CNT_ONE : countAfterGive;
      waitMask  <= (strb.give ? '0 : waitMask) | parkBit;
      wakeVec   <= strb.give ? waitMask : '0;
      blockResp <= strb.park;
      if (strb.tagWr) begin
        tagT <= wrData[TAG_T_BIT];
        tagF <= wrData[TAG_F_BIT];
        tagE <= wrData[TAG_E_BIT];
      end
      case (strb.rdSel)
        RD_ZERO:  rdData <= '0;
        RD_COUNT: rdData <= DATA_W'(countAfterGive);
        RD_TAG:   rdData <= tagWord;
        default:  rdData <= rdData;
      endcase
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |->
      (count == $past(count) + CNT_ONE || count == $past(count) - CNT_ONE));

  // R5
  sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == CNT_MAX) |-> (count >= CNT_MAX - CNT_ONE));

  // R3
  park_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockResp |-> (rdData == '0 && count == '0));

  // R6
  wake_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeVec != '0) |=> (wakeVec == '0));

  generate
    if (FIFO_TAG) begin : g_fifoChk
      // R9
      fifo_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        (count == '0 && waitMask == '0 && !blockResp));
    end
  endgenerate
endmodule

// File: rtl/semaphoreCell.sv
module semaphoreCell
  import semCellPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 64,
  parameter int NUM_THREADS = 8,
  parameter bit FIFO_TAG    = 1'b0,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [3:0]             viewSel,
  input  logic                   rdEn,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [TID_W-1:0]       threadId,
  output logic [DATA_W-1:0]      rdData,
  output logic                   blockResp,
  output logic [NUM_THREADS-1:0] wakeVec
);
  strobeT strb;
  logic   countZero;

  semCellCtrl #(.FIFO_TAG(FIFO_TAG)) u_ctrl (
    .viewSel  (viewSel),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .countZero(countZero),
    .strb     (strb)
  );

  semCellData #(
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .NUM_THREADS(NUM_THREADS),
    .TID_W      (TID_W),
    .FIFO_TAG   (FIFO_TAG)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .threadId (threadId),
    .wrData   (wrData),
    .rdData   (rdData),
    .blockResp(blockResp),
    .wakeVec  (wakeVec),
    .countZero(countZero)
  );
endmodule

// File: tb/test_semaphoreCell.sv
`timescale 1ns/1ps
module test_semaphoreCell;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  viewSel = 4'd0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [2:0]  threadId = '0;
  logic [63:0] rdData;
  logic        blockResp;
  logic [7:0]  wakeVec;

  logic [3:0]  fViewSel = 4'd0;
  logic        fRdEn = 1'b0, fWrEn = 1'b0;
  logic [63:0] fRdData;
  logic        fBlockResp;
  logic [7:0]  fWakeVec;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    bit          chkRd;
    logic [63:0] rd;
    logic        blk;
    logic [7:0]  wake;
    int          due;
    string       tag;
  } expT;
  expT sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  semaphoreCell i_semaphoreCell (
    .clk(clk), .rstN(rstN), .viewSel(viewSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .threadId(threadId), .rdData(rdData),
    .blockResp(blockResp), .wakeVec(wakeVec));

  semaphoreCell #(.FIFO_TAG(1'b1)) i_semaphoreCellFifo (
    .clk(clk), .rstN(rstN), .viewSel(fViewSel), .rdEn(fRdEn), .wrEn(fWrEn),
    .wrData(64'hFFFF_FFFF), .threadId(3'd0), .rdData(fRdData),
    .blockResp(fBlockResp), .wakeVec(fWakeVec));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic [3:0] v, input bit r, input bit w,
                    input logic [63:0] d, input int tid, input bit chkRd,
                    input logic [63:0] expRd, input logic expBlk,
                    input logic [7:0] expWake, input string tag);
    expT e;
    @(negedge clk);
    viewSel = v; rdEn = r; wrEn = w; wrData = d; threadId = 3'(tid);
    e.chkRd = chkRd; e.rd = expRd; e.blk = expBlk; e.wake = expWake;
    e.due = cyc + 1; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    op(4'd0, 1'b0, 1'b0, '0, 0, 1'b0, '0, 1'b0, 8'h00, tag);
  endtask

  // monitor: compare each expectation in the cycle its registered result appears
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      expT e;
      e = sb.pop_front();
      if (e.chkRd) chk(e.tag, "rdData", rdData, e.rd);
      chk(e.tag, "blockResp", 64'(blockResp), 64'(e.blk));
      chk(e.tag, "wakeVec", 64'(wakeVec), 64'(e.wake));
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk("R1", "rdData", rdData, '0);
    chk("R1", "blockResp", 64'(blockResp), '0);
    chk("R1", "wakeVec", 64'(wakeVec), '0);
    @(negedge clk) rstN = 1'b1;

    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R1");
    op(4'd1, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R1");

    // R5 gives ignore data; both views give
    op(4'd5, 0, 1, 64'hDEAD, 0, 0, '0, 0, 8'h00, "R5");
    op(4'd4, 0, 1, 64'hBEEF, 0, 0, '0, 0, 8'h00, "R5");
    op(4'd0, 1, 0, '0, 0, 1, 64'd2, 0, 8'h00, "R5");
    // R2 takes return pre-take count
    op(4'd5, 1, 0, '0, 0, 1, 64'd2, 0, 8'h00, "R2");
    op(4'd4, 1, 0, '0, 0, 1, 64'd1, 0, 8'h00, "R2");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R2");

    // R4 poll at zero: no block, no waiter
    op(4'd5, 1, 0, '0, 6, 1, 64'd0, 0, 8'h00, "R4");
    op(4'd5, 0, 1, '0, 0, 0, '0, 0, 8'h00, "R4");
    op(4'd5, 1, 0, '0, 0, 1, 64'd1, 0, 8'h00, "R4");

    // R3 parking two threads, R6 release
    op(4'd4, 1, 0, '0, 3, 1, 64'd0, 1, 8'h00, "R3");
    op(4'd4, 1, 0, '0, 5, 1, 64'd0, 1, 8'h00, "R3");
    idle("R3");
    op(4'd5, 0, 1, '0, 0, 0, '0, 0, 8'h28, "R6");
    op(4'd4, 0, 1, '0, 0, 0, '0, 0, 8'h00, "R6");
    op(4'd0, 1, 0, '0, 0, 1, 64'd2, 0, 8'h00, "R6");
    op(4'd5, 1, 0, '0, 0, 1, 64'd2, 0, 8'h00, "R2");
    op(4'd5, 1, 0, '0, 0, 1, 64'd1, 0, 8'h00, "R2");

    // R7 raw write ignored
    op(4'd0, 0, 1, 64'h1234, 0, 0, '0, 0, 8'h00, "R7");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R7");

    // R8 tag view layout
    op(4'd1, 0, 1, 64'hFFFF_0000_0001_0003, 0, 0, '0, 0, 8'h00, "R8");
    op(4'd1, 1, 0, '0, 0, 1, 64'h1_0003, 0, 8'h00, "R8");
    op(4'd1, 0, 1, 64'h2, 0, 0, '0, 0, 8'h00, "R8");
    op(4'd1, 1, 0, '0, 0, 1, 64'h2, 0, 8'h00, "R8");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R8");

    // R10 simultaneous take and give, empty mask then with a waiter
    op(4'd4, 1, 1, '0, 2, 1, 64'd1, 0, 8'h00, "R10");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R10");
    op(4'd4, 1, 0, '0, 1, 1, 64'd0, 1, 8'h00, "R10");
    op(4'd4, 1, 1, '0, 2, 1, 64'd1, 0, 8'h02, "R10");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R10");

    // R11 empty/full views inert on this cell
    op(4'd2, 0, 1, 64'h7, 0, 0, '0, 0, 8'h00, "R11");
    op(4'd3, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R11");
    op(4'd2, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R11");
    op(4'd0, 1, 0, '0, 0, 1, 64'd0, 0, 8'h00, "R11");

    // R5 saturation
    for (int i = 0; i < 65540; i++) op(4'd5, 0, 1, '0, 0, 0, '0, 0, 8'h00, "R5");
    op(4'd0, 1, 0, '0, 0, 1, 64'hFFFF, 0, 8'h00, "R5");
    op(4'd4, 0, 1, '0, 0, 0, '0, 0, 8'h00, "R5");
    op(4'd0, 1, 0, '0, 0, 1, 64'hFFFF, 0, 8'h00, "R5");
    op(4'd5, 1, 0, '0, 0, 1, 64'hFFFF, 0, 8'h00, "R5");
    op(4'd0, 1, 0, '0, 0, 1, 64'hFFFE, 0, 8'h00, "R5");
    idle("R5");
    repeat (3) @(negedge clk);

    // R9 FIFO-type cell: semaphore views inert
    @(negedge clk); fViewSel = 4'd4; fWrEn = 1'b1; fRdEn = 1'b0;
    @(negedge clk); fWrEn = 1'b0; fRdEn = 1'b1;
    chk("R9", "wakeVec", 64'(fWakeVec), '0);
    @(negedge clk); fViewSel = 4'd1;
    chk("R9", "rdData", fRdData, '0);
    chk("R9", "blockResp", 64'(fBlockResp), '0);
    @(negedge clk); fViewSel = 4'd0;
    chk("R9", "tagWord", fRdData, 64'h2_0000);
    @(negedge clk); fRdEn = 1'b0;
    chk("R9", "rawCount", fRdData, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule